// File: doc/BRIEF.md
# Three-Personality Bank Mode Controller

This block sits between three cartridge bank-controller cores and the memory address lines. The first core is a nibble-register banker, the second a scanline-IRQ banker and the third a serially loaded banker. A CPU write into the expansion window loads a small mode register. The mode register picks which core's PRG and CHR bank numbers are passed on. On the way out, each bank is masked and ORed with an outer value. When the serial core is active, the mask and OR value are narrowed. One mode bit selects the upper half of CHR space.

The block also tells the cores when they are entered. Each core has a pending-init flag. The first time a core becomes active, it receives a one-cycle init strobe. That strobe is followed by a core-specific follow-up:
- The serial core receives a reset-write pulse on every entry.
- The nibble core receives, on its first entry only, a pulse telling it to load 0xFF into all of its CHR registers.

After reset, the first clock edge counts as an entry into the personality held by the cleared mode register, which is the nibble personality.

Top module: `tri_mode_bank_ctrl`

## Requirements
- R1: A write is accepted only when `cpu_we_i` is high, `cpu_addr_i` lies in 0x4020..0x5FFF inclusive and `cpu_addr_i[8]` is 1. Any other write leaves the mode register, `sel_o` and all strobes unchanged. An accepted write loads `cpu_data_i` into the mode register at that clock edge.
- R2: `sel_o` follows the mode register. It is 2 (serial) when mode bit 1 is 1. Otherwise it is 1 (scanline-IRQ) when mode bit 0 is 1. Otherwise it is 0 (nibble). The same code selects which core's bank inputs are used.
- R3: `prg_bank_o` = (core_prg & mask) | (outer & ~mask), where outer is 0. The mask is 0x3F, and 0x1F when the serial core is selected.
- R4: `chr_bank_o` (9 bits) uses mask 0xFF with mode bit 2 placed in bit 8. When the serial core is selected, the mask is 0x3F and mode bit 2 lands in bit 6, so bits 8:7 are 0.
- R5: While `rst_ni` is low, the mode register is 0, all three pending flags are 1 and all strobes are 0. The first clock edge after reset is an entry into the nibble personality.
- R6: A personality entry happens only on an accepted write whose mode bits 1:0 differ from the stored ones. This includes a change from 2 to 3, which re-enters the serial core. A write that changes only bit 2 raises no strobe.
- R7: `init_o` has bit 0 for nibble, bit 1 for scanline-IRQ and bit 2 for serial. On an entry, the entered personality's bit pulses for one cycle only if its pending flag is set, and the flag is then cleared. The pulse appears in the cycle after the entry edge.
- R8: Every entry into the serial personality raises `ser_rst_wr_o` for one cycle, one cycle after that entry's `init_o` slot.
- R9: `nib_fill_o` pulses for one cycle in the cycle after `init_o[0]` pulses. It pulses at no other time.
- R10: If an accepted mode write lands on the first edge after reset, the write's entry is taken and the boot entry is dropped. If the write leaves the nibble personality selected, the nibble entry still takes place. In every case the nibble flag stays pending until the nibble core is actually entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_we_i | input | 1 | CPU write strobe |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 3 | CPU data bits used for the mode value |
| nib_prg_i | input | 6 | PRG bank from the nibble core |
| nib_chr_i | input | 8 | CHR bank from the nibble core |
| irq_prg_i | input | 6 | PRG bank from the scanline-IRQ core |
| irq_chr_i | input | 8 | CHR bank from the scanline-IRQ core |
| ser_prg_i | input | 6 | PRG bank from the serial core |
| ser_chr_i | input | 8 | CHR bank from the serial core |
| sel_o | output | 2 | Active personality code |
| prg_bank_o | output | 6 | Masked PRG bank |
| chr_bank_o | output | 9 | Masked CHR bank |
| init_o | output | 3 | One-shot first-entry init strobes |
| ser_rst_wr_o | output | 1 | Reset-write pulse to the serial core |
| nib_fill_o | output | 1 | Load-0xFF pulse to the nibble CHR registers |

## Verification
Two entries can compete on the same edge: the boot entry implied by leaving reset, and an entry caused by a mode write.

The bench provokes this by releasing reset and presenting a write to the scanline-IRQ mode in the same low phase. It then checks three things:
- Only `init_o[1]` pulses.
- No fill pulse follows.
- A later return to mode 0 still yields the nibble init strobe followed by the fill pulse.

A second collision is a mode write that changes bits 1:0 while the serial core stays selected (2 to 3). The bench checks that this still produces a reset-write pulse but no repeated init strobe.

// File: rtl/tmb_pkg.sv
package tmb_pkg;
  localparam int unsigned NUM_P = 3;

  typedef enum logic [1:0] {
    P_NIB = 2'd0,
    P_IRQ = 2'd1,
    P_SER = 2'd2
  } persona_e;

  function automatic persona_e decode_mode(input logic [1:0] b);
    if (b[1])      return P_SER;
    else if (b[0]) return P_IRQ;
    else           return P_NIB;
  endfunction
endpackage

// File: rtl/tmb_mode_reg.sv
module tmb_mode_reg #(
  parameter int unsigned          ADDR_W  = 16,
  parameter int unsigned          MODE_W  = 3,
  parameter int unsigned          SEL_BIT = 8,
  parameter logic [ADDR_W-1:0]    WIN_LO  = 'h4020,
  parameter logic [ADDR_W-1:0]    WIN_HI  = 'h5FFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MODE_W-1:0] data_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              chg_o
);
  logic              hit;
  logic [MODE_W-1:0] mode_q;

  assign hit = we_i && (addr_i >= WIN_LO) && (addr_i <= WIN_HI) && addr_i[SEL_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  mode_q <= '0;
    else if (hit) mode_q <= data_i;
  end

  // personality entry: only the selector bits count
  assign chg_o  = hit && (data_i[1:0] != mode_q[1:0]);
  assign mode_o = mode_q;
endmodule

// File: rtl/tmb_init_seq.sv
module tmb_init_seq
  import tmb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chg_i,
  input  persona_e         new_p_i,
  input  persona_e         cur_p_i,
  output logic [NUM_P-1:0] init_o,
  output logic             ser_rst_wr_o,
  output logic             nib_fill_o
);
  logic             boot_q;
  logic [NUM_P-1:0] pend_q;
  logic [NUM_P-1:0] init_q;
  logic             ser_ent_q;
  logic             ser_q;
  logic             fill_q;
  logic             ent_v;
  persona_e         ent_p;

  // a write entry takes the edge over the boot entry
  always_comb begin
    ent_v = chg_i | boot_q;
    ent_p = chg_i ? new_p_i : cur_p_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) boot_q <= 1'b1;
    else         boot_q <= 1'b0;
  end

  for (genvar p = 0; p < NUM_P; p++) begin : g_pend
    logic hit_p;
    assign hit_p = ent_v && (int'(ent_p) == p);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[p] <= 1'b1;
        init_q[p] <= 1'b0;
      end else begin
        init_q[p] <= hit_p && pend_q[p];
        if (hit_p) pend_q[p] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ser_ent_q <= 1'b0;
      ser_q     <= 1'b0;
      fill_q    <= 1'b0;
    end else begin
      ser_ent_q <= ent_v && (ent_p == P_SER);
      ser_q     <= ser_ent_q;
      fill_q    <= init_q[int'(P_NIB)];
    end
  end

  assign init_o       = init_q;
  assign ser_rst_wr_o = ser_q;
  assign nib_fill_o   = fill_q;
endmodule

// File: rtl/tmb_bank_mask.sv
module tmb_bank_mask #(
  parameter int unsigned W     = 6,
  parameter int unsigned SHIFT = 1
) (
  input  logic [W-1:0] bank_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] or_i,
  input  logic         shift_i,
  output logic [W-1:0] bank_o
);
  logic [W-1:0] mask_eff;
  logic [W-1:0] or_eff;

  always_comb begin
    mask_eff = shift_i ? (mask_i >> SHIFT) : mask_i;
    or_eff   = shift_i ? (or_i >> SHIFT) : or_i;
    bank_o   = (bank_i & mask_eff) | (or_eff & ~mask_eff);
  end
endmodule

// File: rtl/tri_mode_bank_ctrl.sv
module tri_mode_bank_ctrl
  import tmb_pkg::*;
#(
  parameter int unsigned PRG_W     = 6,
  parameter int unsigned CHR_W     = 9,
  parameter int unsigned PRG_SHIFT = 1,
  parameter int unsigned CHR_SHIFT = 2,
  parameter int unsigned MODE_W    = 3,
  localparam int unsigned CHR_IN_W = CHR_W - 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cpu_we_i,
  input  logic [15:0]         cpu_addr_i,
  input  logic [MODE_W-1:0]   cpu_data_i,
  input  logic [PRG_W-1:0]    nib_prg_i,
  input  logic [CHR_IN_W-1:0] nib_chr_i,
  input  logic [PRG_W-1:0]    irq_prg_i,
  input  logic [CHR_IN_W-1:0] irq_chr_i,
  input  logic [PRG_W-1:0]    ser_prg_i,
  input  logic [CHR_IN_W-1:0] ser_chr_i,
  output logic [1:0]          sel_o,
  output logic [PRG_W-1:0]    prg_bank_o,
  output logic [CHR_W-1:0]    chr_bank_o,
  output logic [NUM_P-1:0]    init_o,
  output logic                ser_rst_wr_o,
  output logic                nib_fill_o
);
  localparam logic [PRG_W-1:0] PRG_MASK = '1;
  localparam logic [PRG_W-1:0] PRG_OR   = '0;
  localparam logic [CHR_W-1:0] CHR_MASK = {1'b0, {CHR_IN_W{1'b1}}};

  logic [MODE_W-1:0]   mode;
  logic                chg;
  persona_e            cur_p;
  persona_e            new_p;
  logic                is_ser;
  logic [PRG_W-1:0]    prg_sel;
  logic [CHR_IN_W-1:0] chr_sel;
  logic [CHR_W-1:0]    chr_or;

  tmb_mode_reg #(
    .ADDR_W (16),
    .MODE_W (MODE_W),
    .SEL_BIT(8),
    .WIN_LO (16'h4020),
    .WIN_HI (16'h5FFF)
  ) u_mode (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cpu_we_i),
    .addr_i(cpu_addr_i),
    .data_i(cpu_data_i),
    .mode_o(mode),
    .chg_o (chg)
  );

  assign cur_p  = decode_mode(mode[1:0]);
  assign new_p  = decode_mode(cpu_data_i[1:0]);
  assign is_ser = (cur_p == P_SER);

  tmb_init_seq u_init (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .chg_i       (chg),
    .new_p_i     (new_p),
    .cur_p_i     (cur_p),
    .init_o      (init_o),
    .ser_rst_wr_o(ser_rst_wr_o),
    .nib_fill_o  (nib_fill_o)
  );

  always_comb begin
    unique case (cur_p)
      P_IRQ: begin
        prg_sel = irq_prg_i;
        chr_sel = irq_chr_i;
      end
      P_SER: begin
        prg_sel = ser_prg_i;
        chr_sel = ser_chr_i;
      end
      default: begin
        prg_sel = nib_prg_i;
        chr_sel = nib_chr_i;
      end
    endcase
  end

  // mode bit 2 is the upper CHR half, placed just above the base mask
  assign chr_or = {mode[2], {CHR_IN_W{1'b0}}};

  tmb_bank_mask #(.W(PRG_W), .SHIFT(PRG_SHIFT)) u_prg_mask (
    .bank_i (prg_sel),
    .mask_i (PRG_MASK),
    .or_i   (PRG_OR),
    .shift_i(is_ser),
    .bank_o (prg_bank_o)
  );

  tmb_bank_mask #(.W(CHR_W), .SHIFT(CHR_SHIFT)) u_chr_mask (
    .bank_i ({1'b0, chr_sel}),
    .mask_i (CHR_MASK),
    .or_i   (chr_or),
    .shift_i(is_ser),
    .bank_o (chr_bank_o)
  );

  assign sel_o = cur_p;
endmodule

// File: rtl/tmb_checker.sv
module tmb_checker
  import tmb_pkg::*;
#(
  parameter int unsigned PRG_W = 6,
  parameter int unsigned CHR_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cpu_we_i,
  input logic [1:0]       sel_o,
  input logic [PRG_W-1:0] prg_bank_o,
  input logic [CHR_W-1:0] chr_bank_o,
  input logic [NUM_P-1:0] init_o,
  input logic             ser_rst_wr_o,
  input logic             nib_fill_o
);
  logic [NUM_P-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else         seen_q <= seen_q | init_o;
  end

  AST_SEL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o != 2'd3); // R2
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cpu_we_i) |-> $stable(sel_o)); // R1
  AST_SER_PRG_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == 2'd2) |-> (prg_bank_o < PRG_W'(1 << (PRG_W - 1)))); // R3
  AST_SER_CHR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == 2'd2) |-> (chr_bank_o < CHR_W'(1 << (CHR_W - 2)))); // R4
  AST_INIT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(init_o)); // R7
  AST_INIT_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_o & seen_q) == '0); // R7
  AST_SER_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o[2] |=> ser_rst_wr_o); // R8
  AST_SER_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_rst_wr_o |-> ($past(sel_o) == 2'd2)); // R8
  AST_FILL_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_fill_o |-> $past(init_o[0])); // R9
  AST_FILL_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o[0] |=> nib_fill_o); // R9
endmodule

bind tri_mode_bank_ctrl tmb_checker u_chk (.*);

// File: tb/tb_tri_mode_bank_ctrl.sv
module tb_tri_mode_bank_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_we_i = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic [2:0]  cpu_data_i = '0;
  logic [5:0]  nib_prg_i = '0, irq_prg_i = '0, ser_prg_i = '0;
  logic [7:0]  nib_chr_i = '0, irq_chr_i = '0, ser_chr_i = '0;
  logic [1:0]  sel_o;
  logic [5:0]  prg_bank_o;
  logic [8:0]  chr_bank_o;
  logic [2:0]  init_o;
  logic        ser_rst_wr_o;
  logic        nib_fill_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [2:0] mode_m;
  logic [2:0] pend_m;

  always #10 clk_i = ~clk_i;

  tri_mode_bank_ctrl dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int pf(input logic [2:0] d);
    return d[1] ? 2 : (d[0] ? 1 : 0);
  endfunction

  // drive in low phase, check strobes after the edge and one cycle later
  task automatic wr_chk(input logic [15:0] a, input logic [2:0] d, input string tag);
    bit acc, chg;
    int np;
    logic [2:0] e_init;
    bit e_ser, e_fill;
    acc = (a >= 16'h4020) && (a <= 16'h5FFF) && a[8];
    chg = acc && (d[1:0] != mode_m[1:0]);
    np = pf(d);
    e_init = '0; e_ser = 1'b0; e_fill = 1'b0;
    if (acc) mode_m = d;
    if (chg) begin
      e_init[np] = pend_m[np];
      pend_m[np] = 1'b0;
      e_ser = (np == 2);
      e_fill = e_init[0];
    end
    cpu_we_i = 1'b1; cpu_addr_i = a; cpu_data_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    cpu_we_i = 1'b0;
    chk(init_o == e_init, {tag, " init"}, init_o, e_init);
    chk(sel_o == 2'(pf(mode_m)), {tag, " sel"}, sel_o, pf(mode_m));
    chk(!ser_rst_wr_o && !nib_fill_o, {tag, " early follow"}, {ser_rst_wr_o, nib_fill_o}, 0);
    @(negedge clk_i);
    chk(init_o == 3'b000, {tag, " init clear"}, init_o, 0);
    chk(ser_rst_wr_o == e_ser, {tag, " ser_rst"}, ser_rst_wr_o, e_ser);
    chk(nib_fill_o == e_fill, {tag, " fill"}, nib_fill_o, e_fill);
  endtask

  task automatic sweep(input logic [2:0] m);
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      logic [5:0] cp;
      logic [7:0] cc;
      logic [5:0] ep;
      logic [8:0] ec;
      int s;
      @(negedge clk_i);
      b = 8'(v);
      nib_prg_i = b[5:0]; irq_prg_i = ~b[5:0]; ser_prg_i = b[5:0] ^ 6'h2A;
      nib_chr_i = b; irq_chr_i = b ^ 8'hC3; ser_chr_i = ~b;
      s = pf(m);
      cp = (s == 2) ? ser_prg_i : (s == 1) ? irq_prg_i : nib_prg_i;
      cc = (s == 2) ? ser_chr_i : (s == 1) ? irq_chr_i : nib_chr_i;
      ep = (s == 2) ? (cp & 6'h1F) : cp;
      ec = (s == 2) ? ({1'b0, cc & 8'h3F} | (9'(m[2]) << 6)) : {m[2], cc};
      #2;
      chk(prg_bank_o == ep, "R3 prg sweep", prg_bank_o, ep);
      chk(chr_bank_o == ec, "R4 chr sweep", chr_bank_o, ec);
      chk(sel_o == 2'(s), "R2 sel sweep", sel_o, s);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    mode_m = '0;
    pend_m = 3'b111;
  endtask

  initial begin
    mode_m = '0;
    pend_m = 3'b111;
    repeat (2) @(negedge clk_i);
    // R5: state held in reset
    chk(sel_o == 2'd0, "R5 reset sel", sel_o, 0);
    chk(init_o == 3'b000 && !ser_rst_wr_o && !nib_fill_o, "R5 reset strobes",
        {init_o, ser_rst_wr_o, nib_fill_o}, 0);
    chk(prg_bank_o == 6'd0 && chr_bank_o == 9'd0, "R5 reset banks", chr_bank_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(init_o == 3'b001, "R5 boot entry init", init_o, 1);
    pend_m[0] = 1'b0;
    @(negedge clk_i);
    chk(nib_fill_o == 1'b1, "R9 boot fill", nib_fill_o, 1);
    chk(init_o == 3'b000, "R7 boot init single", init_o, 0);
    @(negedge clk_i);
    chk(nib_fill_o == 1'b0, "R9 fill single", nib_fill_o, 0);

    wr_chk(16'h4100, 3'd4, "R6 bit2 only");
    wr_chk(16'h5FFF, 3'd1, "R7 irq first");
    wr_chk(16'h4100, 3'd0, "R7 nib reentry");
    wr_chk(16'h4120, 3'd2, "R8 ser first");
    wr_chk(16'h4100, 3'd3, "R6 ser 2to3");
    wr_chk(16'h5F00, 3'd6, "R8 ser bit2");
    // R1: rejected writes
    wr_chk(16'h4020, 3'd1, "R1 bit8 clear");
    wr_chk(16'h3FFF, 3'd1, "R1 below window");
    wr_chk(16'h6100, 3'd0, "R1 above window");
    wr_chk(16'h5EFF, 3'd5, "R1 bit8 clear high");
    chk(sel_o == 2'd2, "R1 mode kept", sel_o, 2);
    wr_chk(16'h5F00, 3'd1, "R7 irq reentry");
    wr_chk(16'h4100, 3'd2, "R8 ser reentry");

    for (int m = 0; m < 8; m++) begin
      wr_chk(16'h4100 | 16'(m << 9), 3'(m), "R2 sweep entry");
      sweep(3'(m));
    end

    // R10: mode write on the first edge after reset
    do_reset();
    rst_ni = 1'b1;
    wr_chk(16'h4100, 3'd1, "R10 boot collision");
    chk(init_o == 3'b000, "R10 no nib init", init_o, 0);
    wr_chk(16'h4100, 3'd0, "R10 nib still pending");
    wr_chk(16'h4100, 3'd2, "R10 ser after collision");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule